// File: doc/BRIEF.md
# Three-Sample Block Summer

This block accepts a stream of unsigned 10-bit samples. An enable qualifies each sample, and only enabled samples count. Every three enabled samples form one group, and the block reports the sum of that group. Groups never overlap: the first three enabled samples after reset give one sum, the next three give the next sum, and so on. The block never produces a running window sum, and it never reports a half-filled group from start-up.

A three-state phase machine follows the position inside the group:

- `PH_FIRST` goes to `PH_SECOND` on an enabled sample.
- `PH_SECOND` goes to `PH_LAST` on an enabled sample.
- `PH_LAST` goes back to `PH_FIRST` on an enabled sample. This transition is called "close".
- With the enable low, every state stays where it is (the "idle" transition).

In `PH_FIRST` and `PH_SECOND` the sample shifts into a two-entry store. In `PH_LAST` the two stored samples and the incoming sample are added combinationally. The result is registered into a 12-bit output together with a one-cycle valid pulse.

Top module: `tri_block_sum`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, the block goes to the group's first position. After the edge, `sum_vld` reads 0 and `sum_out` reads 0.
- R2: A sample is taken only at a rising edge where `smp_en` is 1. Cycles with `smp_en` low leave the group position and the stored samples unchanged, so idle gaps do not change any sum.
- R3: Each third enabled sample closes a group. The output is the sum of that sample and the two enabled samples before it in the same group. Consecutive groups share no sample.
- R4: After reset, the first two enabled samples give no valid output. The first valid sum covers exactly the first three enabled samples.
- R5: `sum_vld` is 1 for exactly the one cycle after the edge that took a group-closing sample. It is 0 after any edge where `smp_en` was low or where the sample did not close a group.
- R6: `sum_out` changes only together with a valid pulse. Between pulses it holds the last group sum, or 0 after reset.
- R7: `sum_out` is 12 bits wide, so the largest sum, 3 x 1023 = 3069, is reported without overflow.
- R8: A reset in the middle of a group discards the samples already taken. The next valid sum covers only the three enabled samples that follow the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Marks `smp_data` as a sample on this edge |
| smp_data | input | 10 | Unsigned sample value |
| sum_out | output | 12 | Sum of the most recent completed group |
| sum_vld | output | 1 | One-cycle pulse marking a new group sum |

## Verification
The assertions assume that `rst` is held high across at least two rising edges at start-up, so every register holds a defined value before any property is evaluated. They also assume that `smp_en` and `smp_data` are defined and stable around each rising edge. The bench keeps to this: it holds reset for several cycles and changes inputs only on the falling edge. It sweeps every 10-bit value through the data input under several enable gap patterns, adds all-maximum and all-zero groups, and resets in the middle of a group.

// File: rtl/tbs_pkg.sv
package tbs_pkg;

    // Position inside the current group; the encoding follows the sample order.
    typedef enum logic [1:0] {
        PH_FIRST  = 2'd0,
        PH_SECOND = 2'd1,
        PH_LAST   = 2'd2
    } phase_t;

    localparam int GROUP_N = 3;
    localparam int KEEP_N  = GROUP_N - 1;

endpackage

// File: rtl/tbs_phase_fsm.sv
module tbs_phase_fsm
    import tbs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   smp_en,
    output phase_t phase,
    output logic   shift_en,
    output logic   close_grp
);

    phase_t phase_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (rst) phase <= PH_FIRST;
        else     phase <= phase_nxt;
    end

    // Next state and strobes
    always_comb begin
        phase_nxt = phase;
        shift_en  = 1'b0;
        close_grp = 1'b0;
        unique case (phase)
            PH_FIRST: begin
                if (smp_en) begin
                    phase_nxt = PH_SECOND;
                    shift_en  = 1'b1;
                end
            end
            PH_SECOND: begin
                if (smp_en) begin
                    phase_nxt = PH_LAST;
                    shift_en  = 1'b1;
                end
            end
            PH_LAST: begin
                if (smp_en) begin
                    phase_nxt = PH_FIRST;
                    close_grp = 1'b1;
                end
            end
            default: phase_nxt = PH_FIRST;
        endcase
    end

    // R2: an idle cycle leaves the group position alone
    assert_phase_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> $stable(phase));

    // R3: a closing sample always restarts the group
    assert_phase_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        close_grp |=> (phase == PH_FIRST));

    // R3: shifting and closing never happen together
    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(shift_en && close_grp));

endmodule

// File: rtl/tbs_hold_store.sv
module tbs_hold_store #(
    parameter int SAMPLE_W = 10,
    parameter int DEPTH    = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      shift_en,
    input  logic [SAMPLE_W-1:0]       din,
    output logic [DEPTH*SAMPLE_W-1:0] taps
);

    // Slot 0 takes the newest sample; each later slot takes its neighbour.
    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                taps[k*SAMPLE_W +: SAMPLE_W] <= '0;
            end else if (shift_en) begin
                if (k == 0) taps[k*SAMPLE_W +: SAMPLE_W] <= din;
                else        taps[k*SAMPLE_W +: SAMPLE_W] <= taps[(k-1)*SAMPLE_W +: SAMPLE_W];
            end
        end
    end

    // R3: a shifted-in sample lands in the newest slot
    assert_store_load_R3: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (taps[SAMPLE_W-1:0] == $past(din)));

    // R2: without a shift the store is frozen
    assert_store_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(taps));

endmodule

// File: rtl/tbs_result_reg.sv
module tbs_result_reg #(
    parameter int SAMPLE_W = 10,
    parameter int DEPTH    = 2,
    parameter int SUM_W    = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      close_grp,
    input  logic [DEPTH*SAMPLE_W-1:0] taps,
    input  logic [SAMPLE_W-1:0]       din,
    output logic [SUM_W-1:0]          sum_out,
    output logic                      sum_vld
);

    localparam int MAX_SUM = (DEPTH + 1) * ((1 << SAMPLE_W) - 1);

    logic [SUM_W-1:0] total;

    always_comb begin
        total = SUM_W'(din);
        for (int k = 0; k < DEPTH; k++) begin
            total = total + SUM_W'(taps[k*SAMPLE_W +: SAMPLE_W]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_out <= '0;
            sum_vld <= 1'b0;
        end else begin
            sum_vld <= close_grp;
            if (close_grp) sum_out <= total;
        end
    end

    // R5: a pulse only follows a closing sample
    assert_pulse_src_R5: assert property (@(posedge clk) disable iff (rst)
        sum_vld |-> $past(close_grp));

    // R5: never two pulses back to back
    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
        sum_vld |=> !sum_vld);

    // R6: output frozen unless a group closes
    assert_sum_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !close_grp |=> $stable(sum_out));

    // R7: reported sum within the arithmetic range
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        sum_vld |-> (int'(sum_out) <= MAX_SUM));

endmodule

// File: rtl/tri_block_sum.sv
module tri_block_sum
    import tbs_pkg::*;
#(
    parameter int SAMPLE_W = 10,
    localparam int SUM_W   = SAMPLE_W + $clog2(GROUP_N + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_en,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic [SUM_W-1:0]    sum_out,
    output logic                sum_vld
);

    phase_t                     phase;
    logic                       shift_en;
    logic                       close_grp;
    logic [KEEP_N*SAMPLE_W-1:0] taps;

    tbs_phase_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .smp_en    (smp_en),
        .phase     (phase),
        .shift_en  (shift_en),
        .close_grp (close_grp)
    );

    tbs_hold_store #(
        .SAMPLE_W (SAMPLE_W),
        .DEPTH    (KEEP_N)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .din      (smp_data),
        .taps     (taps)
    );

    tbs_result_reg #(
        .SAMPLE_W (SAMPLE_W),
        .DEPTH    (KEEP_N),
        .SUM_W    (SUM_W)
    ) u_result (
        .clk       (clk),
        .rst       (rst),
        .close_grp (close_grp),
        .taps      (taps),
        .din       (smp_data),
        .sum_out   (sum_out),
        .sum_vld   (sum_vld)
    );

    // R5: a closing sample is only possible on an enabled edge in the last position
    assert_close_gate_R5: assert property (@(posedge clk) disable iff (rst)
        close_grp |-> (smp_en && phase == PH_LAST));

endmodule

// File: tb/test_tri_block_sum.sv
`timescale 1ns/1ps
module test_tri_block_sum;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_en = 1'b0;
    logic [9:0] smp_data = '0;
    logic [11:0] sum_out;
    logic       sum_vld;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    // reference model state
    int m_pos  = 0;
    int m_part = 0;
    int m_held = 0;

    always #4 clk = ~clk;

    tri_block_sum i_tri_block_sum (
        .clk      (clk),
        .rst      (rst),
        .smp_en   (smp_en),
        .smp_data (smp_data),
        .sum_out  (sum_out),
        .sum_vld  (sum_vld)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk);
        rst = 1'b1;
        smp_en = 1'b0;
        repeat (cycles) @(posedge clk);
        #1;
        m_pos = 0; m_part = 0; m_held = 0;
        check("R1 valid after reset", int'(sum_vld), 0);
        check("R1 sum after reset", int'(sum_out), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // one clock with the given inputs; outputs checked just after the edge
    task automatic put(input bit en, input int d, input string tag);
        int exp_vld;
        @(negedge clk);
        smp_en = en;
        smp_data = 10'(d);
        @(posedge clk);
        #1;
        exp_vld = 0;
        if (en) begin
            if (m_pos == 2) begin
                exp_vld = 1;
                m_held = m_part + d;
                m_part = 0;
                m_pos = 0;
            end else begin
                m_part += d;
                m_pos++;
            end
        end
        check({tag, " R5 valid"}, int'(sum_vld), exp_vld);
        if (exp_vld == 1) check({tag, " R3 sum"}, int'(sum_out), m_held);
        else              check({tag, " R6 hold"}, int'(sum_out), m_held);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        do_reset(4);

        // R4: first two samples give nothing, third gives first sum
        put(1, 100, "R4 s1");
        check("R4 no early valid", int'(sum_vld), 0);
        put(1, 200, "R4 s2");
        check("R4 no early valid", int'(sum_vld), 0);
        put(1, 300, "R4 s3");
        check("R4 first sum", int'(sum_out), 600);
        put(0, 999, "R5 low after pulse");

        // R7: maximum group
        put(1, 1023, "R7 a"); put(1, 1023, "R7 b"); put(1, 1023, "R7 c");
        check("R7 max sum", int'(sum_out), 3069);
        // zero group
        put(1, 0, "R3 z"); put(1, 0, "R3 z"); put(1, 0, "R3 z");
        check("R3 zero sum", int'(sum_out), 0);

        // R2: idle cycles with changing data between samples
        put(1, 7, "R2 a");
        put(0, 1000, "R2 idle"); put(0, 55, "R2 idle");
        put(1, 8, "R2 b");
        put(0, 321, "R2 idle");
        put(1, 9, "R2 c");
        check("R2 gapped sum", int'(sum_out), 24);

        // Sweep all values under several gap patterns (R3, R5, R6)
        for (int p = 0; p < 3; p++) begin
            for (int v = 0; v < 1024; v++) begin
                if (p == 1 && (v % 4) == 0) put(0, 1023 - v, "R2 sweep idle");
                if (p == 2 && (v % 3) == 1) begin
                    put(0, v, "R2 sweep idle");
                    put(0, v ^ 10'h155, "R2 sweep idle");
                end
                put(1, (p == 0) ? v : (v * 37 + p) % 1024, "R3 sweep");
            end
        end

        // R8: reset mid-group discards partial samples
        put(1, 500, "R8 pre");
        put(1, 400, "R8 pre");
        do_reset(2);
        put(1, 1, "R8 post"); put(1, 2, "R8 post");
        check("R8 no stale valid", int'(sum_vld), 0);
        put(1, 3, "R8 post");
        check("R8 fresh sum", int'(sum_out), 6);

        // R1: reset with one sample taken
        put(1, 77, "R1 pre");
        do_reset(3);
        put(1, 10, "R1 post"); put(1, 20, "R1 post"); put(1, 30, "R1 post");
        check("R1 restart sum", int'(sum_out), 60);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule